// File: doc/BRIEF.md
# Coprocessor Raster/Linear Timer with Interrupt Match

This block is a free-running position timer for a coprocessor. Each advance strobe moves a horizontal position forward by two clock units. In raster mode the horizontal position folds back to zero at the end of a scanline, and that fold steps a line number. The line number returns to zero after a configured count of lines. In linear mode the same two registers act as one long binary counter. The horizontal field holds the low bits, and its carry feeds the vertical field.

Host-held compare values and two enable bits decide when an interrupt pulse is produced. The horizontal compare value counts dots of four clock units. A vertical-only match fires at the start of the matching line. A combined match fires at the chosen dot of the chosen line. The interrupt controller, the processor and the host register decode are outside this block.

Top module: `coproc_hv_timer`

## Requirements
- R1: While rst_ni is low, hpos_o, vpos_o and irq_o are all zero.
- R2: On a cycle with tick_i high, hpos_o advances by 2 before any wrap. On a cycle with tick_i low, neither counter changes.
- R3: In raster mode (linear_i=0), an advance that brings the horizontal position to 1364 or more sets it to 0 and increments vpos_o.
- R4: In raster mode, a vertical increment that brings vpos_o to lines_i or more sets vpos_o to 0.
- R5: In linear mode (linear_i=1), hpos_o is an 11-bit field. Its carry out of bit 10 adds one to the 9-bit vpos_o, and both fields wrap modulo their width.
- R6: With the enable code {ven_i,hen_i}=2'b00, irq_o never goes high.
- R7: With code 2'b01, irq_o fires on an advance whose new hpos_o equals hcmp_i*4.
- R8: With code 2'b10, irq_o fires on an advance whose new vpos_o equals vcmp_i and whose new hpos_o is 0.
- R9: With code 2'b11, irq_o fires on an advance whose new vpos_o equals vcmp_i and whose new hpos_o equals hcmp_i*4.
- R10: irq_o is a one-cycle pulse. It is high in the cycle right after the advancing edge, the same cycle in which the new counter values appear, and it is low in every cycle that follows an edge without an advance.
- R11: A change of linear_i applies from the next advance, and the change does not clear either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance strobe, one per two clock units |
| linear_i | input | 1 | 1 = linear counting, 0 = raster counting |
| hen_i | input | 1 | Horizontal match enable |
| ven_i | input | 1 | Vertical match enable |
| hcmp_i | input | 9 | Horizontal compare, in dots of 4 clock units |
| vcmp_i | input | 9 | Vertical compare, in lines |
| lines_i | input | 9 | Number of lines per frame in raster mode |
| hpos_o | output | 11 | Horizontal position |
| vpos_o | output | 9 | Vertical position |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The counters can only be reached by ticking, so the line and frame wraps are the hardest states to bring about. The stimulus sets a frame of three lines, which lets a few thousand advances cross several scanline ends and frame ends. The linear carry into the vertical field is reached by switching modes partway through a line and continuing past the 11-bit rollover. This also drives the horizontal field above the raster end of line without any fold. A reference model in the bench follows every advance, and it predicts the counters and the interrupt from the enable code in force at the time.

// File: rtl/hv_timer_pkg.sv
package hv_timer_pkg;
  localparam int unsigned H_W = 11;
  localparam int unsigned V_W = 9;
  localparam int unsigned CMP_W = 9;

  typedef enum logic [1:0] {
    SEL_OFF = 2'b00,
    SEL_H   = 2'b01,
    SEL_V   = 2'b10,
    SEL_HV  = 2'b11
  } irq_sel_e;
endpackage

// File: rtl/hv_counter.sv
module hv_counter #(
  parameter int unsigned H_W    = 11,
  parameter int unsigned V_W    = 9,
  parameter int unsigned H_STEP = 2,
  parameter int unsigned H_WRAP = 1364
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           linear_i,
  input  logic [V_W-1:0] lines_i,
  output logic [H_W-1:0] h_q,
  output logic [V_W-1:0] v_q,
  output logic [H_W-1:0] h_nxt,
  output logic [V_W-1:0] v_nxt
);
  localparam int unsigned SUM_W = H_W + 1;

  logic [SUM_W-1:0] h_sum;
  logic [V_W-1:0]   v_inc;
  logic             line_end;

  assign h_sum    = {1'b0, h_q} + SUM_W'(H_STEP);
  assign v_inc    = v_q + V_W'(1);
  assign line_end = h_sum >= SUM_W'(H_WRAP);

  always_comb begin
    h_nxt = h_q;
    v_nxt = v_q;
    if (tick_i) begin
      if (linear_i) begin
        h_nxt = h_sum[H_W-1:0];
        v_nxt = v_q + V_W'(h_sum[H_W]);
      end else if (line_end) begin
        h_nxt = '0;
        v_nxt = (v_inc >= lines_i) ? '0 : v_inc;
      end else begin
        h_nxt = h_sum[H_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_nxt;
      v_q <= v_nxt;
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(h_q) && $stable(v_q)));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !linear_i && ({1'b0, h_q} + SUM_W'(H_STEP) < SUM_W'(H_WRAP)))
      |=> (h_q == $past(h_q) + H_W'(H_STEP)));

  assert_line_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !linear_i && ({1'b0, h_q} + SUM_W'(H_STEP) >= SUM_W'(H_WRAP)))
      |=> (h_q == '0));

  assert_frame_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !linear_i && ({1'b0, h_q} + SUM_W'(H_STEP) >= SUM_W'(H_WRAP))
      && (v_q + V_W'(1) >= lines_i)) |=> (v_q == '0));

  assert_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && linear_i && (h_q == {H_W{1'b1}} - H_W'(H_STEP - 1)))
      |=> (h_q == '0 && v_q == $past(v_q) + V_W'(1)));
endmodule

// File: rtl/irq_match.sv
module irq_match
  import hv_timer_pkg::*;
#(
  parameter int unsigned H_W       = 11,
  parameter int unsigned V_W       = 9,
  parameter int unsigned CMP_W     = 9,
  parameter int unsigned DOT_SHIFT = 2
) (
  input  irq_sel_e         sel_i,
  input  logic [H_W-1:0]   h_i,
  input  logic [V_W-1:0]   v_i,
  input  logic [CMP_W-1:0] hcmp_i,
  input  logic [V_W-1:0]   vcmp_i,
  output logic             hit_o
);
  logic [H_W-1:0] h_target;
  logic           h_eq, v_eq, h_zero;

  assign h_target = H_W'(hcmp_i) << DOT_SHIFT;
  assign h_eq     = h_i == h_target;
  assign v_eq     = v_i == vcmp_i;
  assign h_zero   = h_i == '0;

  always_comb begin
    unique case (sel_i)
      SEL_OFF: hit_o = 1'b0;
      SEL_H:   hit_o = h_eq;
      SEL_V:   hit_o = v_eq && h_zero;
      SEL_HV:  hit_o = v_eq && h_eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/coproc_hv_timer.sv
module coproc_hv_timer
  import hv_timer_pkg::*;
#(
  parameter int unsigned H_STEP    = 2,
  parameter int unsigned H_WRAP    = 1364,
  parameter int unsigned DOT_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             linear_i,
  input  logic             hen_i,
  input  logic             ven_i,
  input  logic [CMP_W-1:0] hcmp_i,
  input  logic [V_W-1:0]   vcmp_i,
  input  logic [V_W-1:0]   lines_i,
  output logic [H_W-1:0]   hpos_o,
  output logic [V_W-1:0]   vpos_o,
  output logic             irq_o
);
  logic [H_W-1:0] h_nxt;
  logic [V_W-1:0] v_nxt;
  logic           hit;
  logic           irq_q;
  irq_sel_e       sel;

  assign sel = irq_sel_e'({ven_i, hen_i});

  hv_counter #(
    .H_W(H_W), .V_W(V_W), .H_STEP(H_STEP), .H_WRAP(H_WRAP)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .linear_i(linear_i),
    .lines_i(lines_i), .h_q(hpos_o), .v_q(vpos_o), .h_nxt(h_nxt), .v_nxt(v_nxt)
  );

  irq_match #(
    .H_W(H_W), .V_W(V_W), .CMP_W(CMP_W), .DOT_SHIFT(DOT_SHIFT)
  ) u_match (
    .sel_i(sel), .h_i(h_nxt), .v_i(v_nxt), .hcmp_i(hcmp_i), .vcmp_i(vcmp_i),
    .hit_o(hit)
  );

  // match is judged on the post-advance counters, registered with them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= tick_i && hit;
  end
  assign irq_o = irq_q;

  assert_irq_needs_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  assert_irq_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(hen_i || ven_i));

  assert_v_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(ven_i && !hen_i)) |-> (hpos_o == '0 && vpos_o == $past(vcmp_i)));

  assert_hv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(ven_i && hen_i))
      |-> (vpos_o == $past(vcmp_i) && hpos_o == (H_W'($past(hcmp_i)) << DOT_SHIFT)));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (hpos_o == '0 && vpos_o == '0 && !irq_o);
  end
endmodule

// File: tb/sim_coproc_hv_timer.sv
`timescale 1ns/1ps
module sim_coproc_hv_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       linear_i = 1'b0;
  logic       hen_i = 1'b0;
  logic       ven_i = 1'b0;
  logic [8:0] hcmp_i = '0;
  logic [8:0] vcmp_i = '0;
  logic [8:0] lines_i = 9'd3;
  logic [10:0] hpos_o;
  logic [8:0]  vpos_o;
  logic        irq_o;

  typedef struct {
    int    h;
    int    v;
    bit    irq;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    errors = 0;
  int    checks = 0;
  int    mh = 0;
  int    mv = 0;
  int    irq_seen = 0;
  bit    done = 1'b0;

  always #5 clk_i = ~clk_i;

  coproc_hv_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .linear_i(linear_i),
    .hen_i(hen_i), .ven_i(ven_i), .hcmp_i(hcmp_i), .vcmp_i(vcmp_i),
    .lines_i(lines_i), .hpos_o(hpos_o), .vpos_o(vpos_o), .irq_o(irq_o)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: advance once, predict from the requirements, queue the expectation
  task automatic tick_n(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      bit   hit;
      @(negedge clk_i);
      tick_i = 1'b1;
      mh += 2;
      if (linear_i) begin
        if (mh >= 2048) begin mh -= 2048; mv = (mv + 1) % 512; end
      end else if (mh >= 1364) begin
        mh = 0;
        mv++;
        if (mv >= int'(lines_i)) mv = 0;
      end
      case ({ven_i, hen_i})
        2'b01:   hit = (mh == int'(hcmp_i) * 4);
        2'b10:   hit = (mv == int'(vcmp_i)) && (mh == 0);
        2'b11:   hit = (mv == int'(vcmp_i)) && (mh == int'(hcmp_i) * 4);
        default: hit = 1'b0;
      endcase
      e.h = mh; e.v = mv; e.irq = hit; e.tag = tag;
      sb.push_back(e);
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  // monitor: compare after each edge; non-advance edges must show no pulse (R10)
  always @(posedge clk_i) begin
    if (rst_ni && !done) begin
      if (tick_i) begin
        #2;
        if (sb.size() == 0) begin
          check(1'b0, "R2", "scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(hpos_o) == e.h, e.tag, "hpos", int'(hpos_o), e.h);
          check(int'(vpos_o) == e.v, e.tag, "vpos", int'(vpos_o), e.v);
          check(irq_o == e.irq, e.tag, "irq", int'(irq_o), int'(e.irq));
          if (irq_o) irq_seen++;
        end
      end else begin
        #2;
        check(irq_o == 1'b0, "R10", "irq without advance", int'(irq_o), 0);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int h0, v0, seen0;
    repeat (3) @(negedge clk_i);
    check(hpos_o == '0 && vpos_o == '0 && irq_o == 1'b0, "R1", "reset state",
          int'(hpos_o) + int'(vpos_o) + int'(irq_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(hpos_o == '0, "R2", "idle hold", int'(hpos_o), 0);

    // R7: horizontal-only match at dot 5 (clock 20), crossing line ends (R3)
    hen_i = 1'b1; ven_i = 1'b0; hcmp_i = 9'd5;
    seen0 = irq_seen;
    tick_n(1400, "R7");
    check(irq_seen - seen0 == 3, "R7", "pulse count", irq_seen - seen0, 3);
    tick_n(10, "R3");

    // R8 and R4: vertical-only match on line 1, frame of 3 lines
    hen_i = 1'b0; ven_i = 1'b1; vcmp_i = 9'd1;
    seen0 = irq_seen;
    tick_n(2100, "R8");
    check(irq_seen - seen0 == 1, "R8", "pulse count", irq_seen - seen0, 1);
    tick_n(700, "R4");

    // R9: combined match dot 100 of line 2
    hen_i = 1'b1; ven_i = 1'b1; hcmp_i = 9'd100; vcmp_i = 9'd2;
    seen0 = irq_seen;
    tick_n(2100, "R9");
    check(irq_seen - seen0 == 1, "R9", "pulse count", irq_seen - seen0, 1);

    // R6: no enables
    hen_i = 1'b0; ven_i = 1'b0;
    seen0 = irq_seen;
    tick_n(700, "R6");
    check(irq_seen == seen0, "R6", "pulse count", irq_seen - seen0, 0);

    // R11: switch to linear mid-line, counters kept
    tick_n(100, "R2");
    @(negedge clk_i);
    h0 = int'(hpos_o); v0 = int'(vpos_o);
    linear_i = 1'b1;
    @(negedge clk_i);
    check(int'(hpos_o) == h0 && int'(vpos_o) == v0, "R11", "no clear on mode change",
          int'(hpos_o), h0);
    tick_n(1, "R11");

    // R5: run past 1364 and the 11-bit rollover, h match at 1200
    hen_i = 1'b1; hcmp_i = 9'd300;
    tick_n(1100, "R5");
    check(int'(vpos_o) == (v0 + 1) % 512, "R5", "carry into vpos", int'(vpos_o), (v0 + 1) % 512);

    // R11: back to raster
    @(negedge clk_i);
    linear_i = 1'b0;
    hen_i = 1'b0; ven_i = 1'b1; vcmp_i = 9'd0;
    tick_n(1400, "R11");

    repeat (3) @(negedge clk_i);
    check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule